// File: doc/BRIEF.md
# BCD Seven-Segment Digit Driver with Zero Suppression

This block turns a 4-bit binary-coded decimal value into the seven segment drive lines of one common-anode display digit. A segment is lit by pulling its line low. Three active-low controls change the normal glyph. The lamp-check control lights every segment. The blank control darkens the digit. The zero-suppress input darkens the digit only when the digit holds zero.

The block has no clock and no state. A row of digits is chained by feeding the zero-suppress output of a more significant digit into the zero-suppress input of the next less significant digit. The most significant digit has its input tied low. Leading zeros then go dark, and the first non-zero digit ends the suppression. Codes above nine are not decimal digits, so they leave the digit dark. A parameter chooses between tail-less glyphs for six and nine (the default) and tailed glyphs.

Top module: `bcd_seg_decoder`

## Requirements
- R1: The segment bus is active-low, with bit 6 = a, bit 5 = b, bit 4 = c, bit 3 = d, bit 2 = e, bit 1 = f and bit 0 = g. A 0 on a bit lights that segment.
- R2: With all three controls high, codes 0 to 4 drive the bus (bit 6 down to bit 0) to 0000001, 1001111, 0010010, 0000110 and 1001100.
- R3: With all three controls high, codes 5 to 9 drive 0100100, 1100000, 0001111, 0000000 and 0001100. Six and nine have no tail (default build).
- R4: With lamp check high, any code from 10 to 15 drives the bus to 1111111.
- R5: With lamp check low, the bus is 0000000 whatever the code, blank and zero-suppress inputs are.
- R6: With lamp check high and blank low, the bus is 1111111 whatever the code and zero-suppress input are.
- R7: With lamp check and blank high and zero-suppress input low, code 0 gives 1111111. Codes 1 to 9 show their normal glyph.
- R8: The zero-suppress output is low exactly when the zero-suppress input is low, the code is 0 and lamp check is high. In every other case it is high.
- R9: With all controls high, the zero-suppress output is high for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bcd_i | input | 4 | Digit code, bit 3 most significant |
| lamp_chk_n_i | input | 1 | Active-low: light all segments |
| blank_n_i | input | 1 | Active-low: darken the digit |
| zs_in_n_i | input | 1 | Active-low: suppress this digit if it is zero |
| seg_n_o | output | 7 | Active-low segments, bit 6 = a down to bit 0 = g |
| zs_out_n_o | output | 1 | Active-low: suppression passes to the next digit |

## Verification
The bench builds the block with its default parameter, TAILED_69 = 0, so the tail-less six and nine glyphs are the ones compared. A vector table covers every glyph, the dark codes above nine, and each control acting alone or against the others. A sweep then drives all 128 combinations of code and control levels. This sweep reaches every priority conflict, for example lamp check against blank, and blank against zero suppression on code 0. In each conflict the chain output must still follow its own rule.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int unsigned CODE_W = 4;
  localparam int unsigned SEG_W  = 7;
  localparam int unsigned MAX_DIGIT = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  typedef enum logic [1:0] {
    MODE_SHOW = 2'd0,
    MODE_TEST = 2'd1,
    MODE_DARK = 2'd2
  } drive_mode_e;

  localparam seg_t SEG_NONE = '0;
  localparam seg_t SEG_ALL  = '1;

  // Positive-logic glyph, bit 6 = a ... bit 0 = g, 1 = lit
  function automatic seg_t glyph_lit(input code_t code, input bit tailed);
    seg_t g;
    case (code)
      4'd0: g = 7'b1111110;
      4'd1: g = 7'b0110000;
      4'd2: g = 7'b1101101;
      4'd3: g = 7'b1111001;
      4'd4: g = 7'b0110011;
      4'd5: g = 7'b1011011;
      4'd6: g = tailed ? 7'b1011111 : 7'b0011111;
      4'd7: g = 7'b1110000;
      4'd8: g = 7'b1111111;
      4'd9: g = tailed ? 7'b1111011 : 7'b1110011;
      default: g = SEG_NONE;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
  import seg_pkg::*;
#(
  parameter bit TAILED_69 = 1'b0
) (
  input  code_t code_i,
  output seg_t  lit_o,
  output logic  valid_o
);

  assign valid_o = (code_i <= code_t'(MAX_DIGIT));
  assign lit_o   = glyph_lit(code_i, TAILED_69);

endmodule

// File: rtl/seg_blank_ctrl.sv
module seg_blank_ctrl
  import seg_pkg::*;
(
  input  code_t       code_i,
  input  logic        valid_i,
  input  logic        lamp_chk_n_i,
  input  logic        blank_n_i,
  input  logic        zs_in_n_i,
  output drive_mode_e mode_o,
  output logic        zs_out_n_o
);

  logic is_zero;
  logic suppress;

  assign is_zero  = (code_i == '0);
  assign suppress = !zs_in_n_i && is_zero;

  assign zs_out_n_o = !(suppress && lamp_chk_n_i);

  always_comb begin
    if (!lamp_chk_n_i)      mode_o = MODE_TEST;
    else if (!blank_n_i)    mode_o = MODE_DARK;
    else if (suppress)      mode_o = MODE_DARK;
    else if (!valid_i)      mode_o = MODE_DARK;
    else                    mode_o = MODE_SHOW;
  end

endmodule

// File: rtl/seg_drive.sv
module seg_drive
  import seg_pkg::*;
(
  input  drive_mode_e mode_i,
  input  seg_t        lit_i,
  output seg_t        seg_n_o
);

  seg_t lit_sel;

  always_comb begin
    unique case (mode_i)
      MODE_TEST: lit_sel = SEG_ALL;
      MODE_SHOW: lit_sel = lit_i;
      default:   lit_sel = SEG_NONE;
    endcase
  end

  // common-anode: a lit segment is a low line
  for (genvar s = 0; s < SEG_W; s++) begin : g_pol
    assign seg_n_o[s] = ~lit_sel[s];
  end

endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import seg_pkg::*;
#(
  parameter bit TAILED_69 = 1'b0
) (
  input  logic [3:0] bcd_i,
  input  logic       lamp_chk_n_i,
  input  logic       blank_n_i,
  input  logic       zs_in_n_i,
  output logic [6:0] seg_n_o,
  output logic       zs_out_n_o
);

  seg_t        lit;
  logic        valid;
  drive_mode_e mode;

  seg_glyph_rom #(.TAILED_69(TAILED_69)) i_rom (
    .code_i  (bcd_i),
    .lit_o   (lit),
    .valid_o (valid)
  );

  seg_blank_ctrl i_ctrl (
    .code_i       (bcd_i),
    .valid_i      (valid),
    .lamp_chk_n_i (lamp_chk_n_i),
    .blank_n_i    (blank_n_i),
    .zs_in_n_i    (zs_in_n_i),
    .mode_o       (mode),
    .zs_out_n_o   (zs_out_n_o)
  );

  seg_drive i_drive (
    .mode_i  (mode),
    .lit_i   (lit),
    .seg_n_o (seg_n_o)
  );

endmodule

// File: rtl/seg_dec_checker.sv
module seg_dec_checker (
  input logic [3:0] bcd_i,
  input logic       lamp_chk_n_i,
  input logic       blank_n_i,
  input logic       zs_in_n_i,
  input logic [6:0] seg_n_o,
  input logic       zs_out_n_o
);

  logic known;
  assign known = !$isunknown({bcd_i, lamp_chk_n_i, blank_n_i, zs_in_n_i});

  always_comb begin
    if (known) begin
      if (!lamp_chk_n_i)
        AST_LAMP_ALL_LIT: assert (seg_n_o == 7'b0000000); // R5
      if (lamp_chk_n_i && !blank_n_i)
        AST_BLANK_DARK: assert (seg_n_o == 7'b1111111); // R6
      if (lamp_chk_n_i && bcd_i > 4'd9)
        AST_BAD_CODE_DARK: assert (seg_n_o == 7'b1111111); // R4
      if (lamp_chk_n_i && !zs_in_n_i && bcd_i == 4'd0)
        AST_ZERO_SUPPRESSED: assert (seg_n_o == 7'b1111111); // R7
      AST_CHAIN_OUT: assert (zs_out_n_o == !(!zs_in_n_i && bcd_i == 4'd0 && lamp_chk_n_i)); // R8
      if (lamp_chk_n_i && blank_n_i && zs_in_n_i && bcd_i == 4'd1)
        AST_ONE_TWO_SEGS: assert ($countones(~seg_n_o) == 2); // R2
    end
  end

endmodule

bind bcd_seg_decoder seg_dec_checker i_chk (
  .bcd_i        (bcd_i),
  .lamp_chk_n_i (lamp_chk_n_i),
  .blank_n_i    (blank_n_i),
  .zs_in_n_i    (zs_in_n_i),
  .seg_n_o      (seg_n_o),
  .zs_out_n_o   (zs_out_n_o)
);

// File: tb/test_bcd_seg_decoder.sv
module test_bcd_seg_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic [3:0] bcd = 4'd0;
  logic       lt_n = 1'b1, bl_n = 1'b1, zi_n = 1'b1;
  logic [6:0] seg_n;
  logic       zo_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_seg_decoder i_bcd_seg_decoder (
    .bcd_i        (bcd),
    .lamp_chk_n_i (lt_n),
    .blank_n_i    (bl_n),
    .zs_in_n_i    (zi_n),
    .seg_n_o      (seg_n),
    .zs_out_n_o   (zo_n)
  );

  // {code, lamp_n, blank_n, zs_in_n, seg_n, zs_out_n}
  localparam int NV = 18;
  localparam logic [14:0] VEC [NV] = '{
    {4'd0, 3'b111, 7'b0000001, 1'b1}, // R2
    {4'd1, 3'b111, 7'b1001111, 1'b1}, // R2
    {4'd2, 3'b111, 7'b0010010, 1'b1}, // R2
    {4'd3, 3'b111, 7'b0000110, 1'b1}, // R2
    {4'd4, 3'b111, 7'b1001100, 1'b1}, // R2
    {4'd5, 3'b111, 7'b0100100, 1'b1}, // R3
    {4'd6, 3'b111, 7'b1100000, 1'b1}, // R3
    {4'd7, 3'b111, 7'b0001111, 1'b1}, // R3
    {4'd8, 3'b111, 7'b0000000, 1'b1}, // R3
    {4'd9, 3'b111, 7'b0001100, 1'b1}, // R3
    {4'd10, 3'b111, 7'b1111111, 1'b1}, // R4
    {4'd15, 3'b111, 7'b1111111, 1'b1}, // R4
    {4'd0, 3'b110, 7'b1111111, 1'b0}, // R7 R8
    {4'd5, 3'b110, 7'b0100100, 1'b1}, // R7
    {4'd12, 3'b011, 7'b0000000, 1'b1}, // R5
    {4'd8, 3'b101, 7'b1111111, 1'b1}, // R6
    {4'd0, 3'b010, 7'b0000000, 1'b1}, // R5 R8
    {4'd0, 3'b100, 7'b1111111, 1'b0}  // R6 R8
  };

  function automatic logic [6:0] ref_glyph(input logic [3:0] c);
    case (c)
      4'd0: return 7'b0000001; 4'd1: return 7'b1001111;
      4'd2: return 7'b0010010; 4'd3: return 7'b0000110;
      4'd4: return 7'b1001100; 4'd5: return 7'b0100100;
      4'd6: return 7'b1100000; 4'd7: return 7'b0001111;
      4'd8: return 7'b0000000; 4'd9: return 7'b0001100;
      default: return 7'b1111111;
    endcase
  endfunction

  task automatic check(input string tag, input logic [6:0] es, input logic ez);
    total++;
    if (seg_n !== es || zo_n !== ez) begin
      bad++;
      $display("FAIL %s code=%0d ctl=%b%b%b seg=%b/%b zs_out=%b/%b (actual/expected)",
               tag, bcd, lt_n, bl_n, zi_n, seg_n, es, zo_n, ez);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic l, input logic b, input logic z);
    @(negedge clk);
    bcd = c; lt_n = l; bl_n = b; zi_n = z;
    #1;
  endtask

  initial begin
    // idle state after start: controls high, code 0
    @(negedge clk); #1;
    check("R9 idle", 7'b0000001, 1'b1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][14:11], VEC[i][10], VEC[i][9], VEC[i][8]);
      check("R1 table", VEC[i][7:1], VEC[i][0]);
    end

    // exhaustive sweep: all codes, all control levels
    for (int k = 0; k < 128; k++) begin
      logic [3:0] c;
      logic l, b, z;
      logic [6:0] es;
      logic ez;
      string tag;
      c = k[6:3]; l = k[2]; b = k[1]; z = k[0];
      ez = !(!z && c == 4'd0 && l);
      if (!l)                    begin es = 7'b0000000; tag = "R5 sweep"; end
      else if (!b)               begin es = 7'b1111111; tag = "R6 sweep"; end
      else if (!z && c == 4'd0)  begin es = 7'b1111111; tag = "R7 sweep"; end
      else if (c > 4'd9)         begin es = 7'b1111111; tag = "R4 sweep"; end
      else                       begin es = ref_glyph(c); tag = "R9 sweep"; end
      apply(c, l, b, z);
      check(tag, es, ez);
      if (l) begin
        total++;
        if (zo_n !== ez) begin
          bad++;
          $display("FAIL R8 code=%0d zs_out=%b expected=%b", c, zo_n, ez);
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule